// File: doc/BRIEF.md
# Dual-Mode 16-Bit Up Counter

This block keeps a 16-bit up count and lets a single level input choose where its increments come from. In timed mode the count steps once per second, driven by a one-cycle enable pulse that a divider produces from the 100 MHz system clock. In manual mode the count steps once for each press of a push button. The raw button is first synchronised, then debounced, and then reduced to a single pulse on the press edge. This means that a press of any length, including one with contact bounce, produces exactly one step.

Everything runs on the one system clock. The once-per-second source is a clock enable and not a derived clock. The divider length and the debounce window are parameters, so a test bench can shorten them. A synchronous active-low reset clears the count, the divider, the debouncer and the synchronisers. The count wraps from all ones back to zero.

Top module: `dual_mode_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count and all internal state go to zero. After release, the first timed step happens exactly `DIV_CYCLES` edges later.
- R2: With `mode_manual` = 0 (timed mode) held since reset, the count after N rising edges following reset release equals N / `DIV_CYCLES`, rounded down.
- R3: In timed mode, any activity on `btn_raw` leaves the count unchanged apart from the timed steps.
- R4: In manual mode (`mode_manual` = 1), each accepted press adds exactly 1, however long the button is held.
- R5: In manual mode, the divider's pulses never change the count.
- R6: A high level on `btn_raw` lasting H clock cycles is accepted as a press when H >= `DEBOUNCE_CYCLES` and is ignored when H < `DEBOUNCE_CYCLES`. This assumes the button was low and settled before the press.
- R7: A low glitch shorter than `DEBOUNCE_CYCLES` cycles in the middle of a held press does not produce a second step.
- R8: The count is 16 bits wide. The step after 16'hFFFF gives 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz in the target) |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_manual | input | 1 | Increment source select: 0 = timed, 1 = button (asynchronous switch level) |
| btn_raw | input | 1 | Raw push-button level, active high, may bounce |
| count | output | 16 | Current count value |

## Verification
The bench builds its main instance with `DIV_CYCLES` = 8 and `DEBOUNCE_CYCLES` = 4. This makes tick timing exact to the cycle and puts the boundary of the debounce window (3 versus 4 cycles of press) within a few edges. A second instance with `DIV_CYCLES` = 2 steps every other cycle. It reaches the 16'hFFFF to 16'h0000 wrap in about 131 thousand cycles, a test that the default once-per-second rate puts out of reach.

// File: rtl/dmc_pkg.sv
// Shared definitions for the dual-mode counter.
package dmc_pkg;
    localparam int COUNT_W = 16;
    typedef logic [COUNT_W-1:0] count_t;
    // Increment source encoding: matches the mode_manual pin level.
    typedef enum logic {
        SRC_TIMER  = 1'b0,
        SRC_BUTTON = 1'b1
    } inc_src_e;
endpackage

// File: rtl/level_sync.sv
// level_sync: multi-flop synchroniser for a slow asynchronous level.
// Assumes the input changes far slower than clk. Resets to zero.
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tick_divider.sv
// tick_divider: produces a one-cycle enable pulse every DIV_CYCLES clocks.
// Assumes DIV_CYCLES >= 2. The pulse comes when the internal count reaches
// its threshold. Duty cycle is 1/DIV_CYCLES.
module tick_divider #(
    parameter int DIV_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int            W    = $clog2(DIV_CYCLES);
    localparam logic [W-1:0]  LAST = W'(DIV_CYCLES - 1);

    logic [W-1:0] cnt;

    // Pulse when the count sits at its threshold.
    assign tick = (cnt == LAST);

    // Count cycles, restarting after each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    a_r1_divider_cleared: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/press_detector.sv
// press_detector: synchronises a raw button, and accepts a new level only
// after it has held for DEBOUNCE_CYCLES cycles. It then emits one pulse per
// accepted rising level. Assumes DEBOUNCE_CYCLES >= 2 and an active-high button.
module press_detector #(
    parameter int DEBOUNCE_CYCLES = 1_000_000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);
    localparam int           W    = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [W-1:0] LAST = W'(DEBOUNCE_CYCLES - 1);

    logic         synced;
    logic         level;
    logic         level_q;
    logic [W-1:0] cnt;

    level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (btn_raw),
        .q    (synced)
    );

    // Time how long the synchronised input differs from the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (synced == level) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            level <= synced;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Remember the previous accepted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign press = level & ~level_q;

    a_r4_press_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);
    a_r6_level_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt != LAST) |=> $stable(level));
    a_r6_level_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt == LAST && synced != level) |=> (level == $past(synced)));
endmodule

// File: rtl/wrap_counter.sv
// wrap_counter: COUNT_W-bit up counter that steps on a one-cycle enable
// and wraps from all ones to zero.
module wrap_counter
    import dmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   inc,
    output count_t value
);
    // Add one on each enable, and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end

    a_r8_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && inc) |=> (value == COUNT_W'($past(value) + 1'b1)));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !inc) |=> $stable(value));
endmodule

// File: rtl/dual_mode_counter.sv
// dual_mode_counter: 16-bit up counter whose step enable is taken either
// from a periodic divider (timed mode) or from a debounced button press
// (manual mode), as chosen by a synchronised switch level.
// Assumes a single clock domain. The switch and button are asynchronous.
module dual_mode_counter
    import dmc_pkg::*;
#(
    parameter int DIV_CYCLES      = 100_000_000,
    parameter int DEBOUNCE_CYCLES = 1_000_000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_manual,
    input  logic               btn_raw,
    output logic [COUNT_W-1:0] count
);
    logic     mode_s;
    logic     tick;
    logic     press;
    logic     inc;
    inc_src_e src;
    count_t   value;

    level_sync #(.STAGES(SYNC_STAGES)) u_mode_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (mode_manual),
        .q    (mode_s)
    );

    tick_divider #(.DIV_CYCLES(DIV_CYCLES)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    press_detector #(
        .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
        .SYNC_STAGES    (SYNC_STAGES)
    ) u_press (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn_raw(btn_raw),
        .press  (press)
    );

    assign src = inc_src_e'(mode_s);

    // Select the increment source from the synchronised mode.
    always_comb begin
        if (src == SRC_BUTTON) inc = press;
        else                   inc = tick;
    end

    wrap_counter u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (inc),
        .value(value)
    );

    assign count = value;

    a_r3_timer_ignores_button: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && src == SRC_TIMER && !tick) |=> $stable(count));
    a_r5_button_ignores_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && src == SRC_BUTTON && !press) |=> $stable(count));
endmodule

// File: tb/sim_dual_mode_counter.sv
`timescale 1ns/1ps
module sim_dual_mode_counter;
    localparam int DIV = 8;
    localparam int DB  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_manual = 1'b0;
    logic        btn_raw = 1'b0;
    logic [15:0] count;
    logic [15:0] count_fast;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dual_mode_counter #(.DIV_CYCLES(DIV), .DEBOUNCE_CYCLES(DB)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_manual(mode_manual),
        .btn_raw(btn_raw), .count(count)
    );

    // Fast-tick instance used only for the wrap check (R8).
    dual_mode_counter #(.DIV_CYCLES(2), .DEBOUNCE_CYCLES(DB)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_manual(1'b0),
        .btn_raw(1'b0), .count(count_fast)
    );

    // Manual-mode press table: hold-high cycles, low cycles after, expected step.
    localparam int NT = 7;
    localparam int HOLD [NT] = '{12, 3, 4, 300, 1, 8, 2};
    localparam int GAP  [NT] = '{12, 12, 12, 12, 12, 20, 12};
    localparam int STEP [NT] = '{1, 0, 1, 1, 0, 1, 0};

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] exp;

        // R1: reset state and exact first timed step.
        do_reset();
        check("R1 reset value", count, 16'h0000);
        step(DIV - 1);
        check("R1 no step before DIV edges", count, 16'h0000);
        step(1);
        check("R1 first step at DIV edges", count, 16'h0001);

        // R2: timed stepping rate.
        step(DIV * 9);
        check("R2 ten periods", count, 16'd10);

        // R3: button activity in timed mode has no effect.
        do_reset();
        btn_raw = 1'b1; step(12);
        btn_raw = 1'b0; step(12);
        btn_raw = 1'b1; step(12);
        btn_raw = 1'b0; step(12);
        btn_raw = 1'b1; step(32);
        check("R3 timed mode ignores button", count, 16'd10);
        btn_raw = 1'b0;

        // R5: manual mode with no presses holds zero despite the divider.
        mode_manual = 1'b1;
        do_reset();
        step(200);
        check("R5 manual ignores divider", count, 16'h0000);

        // R4/R6: table-driven manual presses.
        exp = 16'h0000;
        for (int i = 0; i < NT; i++) begin
            btn_raw = 1'b1; step(HOLD[i]);
            btn_raw = 1'b0; step(GAP[i]);
            exp = exp + 16'(STEP[i]);
            check($sformatf("R4/R6 table entry %0d hold %0d", i, HOLD[i]), count, exp);
        end
        step(100);
        check("R5 count holds between presses", count, exp);

        // R7: release glitch within a held press.
        btn_raw = 1'b1; step(12);
        btn_raw = 1'b0; step(2);
        btn_raw = 1'b1; step(12);
        btn_raw = 1'b0; step(12);
        exp = exp + 16'd1;
        check("R7 bounce gives single step", count, exp);

        // R1: reset in the middle of a press clears everything.
        btn_raw = 1'b1; step(3);
        mode_manual = 1'b0;
        rst_n = 1'b0;
        step(2);
        check("R1 mid-run reset clears count", count, 16'h0000);
        btn_raw = 1'b0;
        rst_n = 1'b1;
        step(DIV - 1);
        check("R1 divider restarted", count, 16'h0000);
        step(1);
        check("R1 divider first step", count, 16'h0001);

        // R8: wrap on the fast instance (steps every 2 edges).
        do_reset();
        step(131070);
        check("R8 reaches FFFF", count_fast, 16'hFFFF);
        step(2);
        check("R8 wraps to 0000", count_fast, 16'h0000);

        done = 1'b1;
        finish_run();
    end
endmodule